// File: doc/BRIEF.md
# Multichannel Scan Timing Controller

This block paces a multichannel acquisition on a single system clock. A start request, issued either as a software pulse or as a rising edge on a hardware input, opens an acquisition. After a programmable number of timebase ticks the first scan begins. Each later scan begins on a sample-clock tick. Within a scan, every convert-clock tick converts one channel, stepping an index from channel 0 up to a programmable last channel. Both clocks are chosen per acquisition. Each can be an internal divider of the timebase enable or an edge on an external level input, with the edge polarity selectable.

In normal mode the acquisition ends after a programmed number of scans. In pretrigger mode, scans run without limit until a reference trigger is accepted. A fixed number of further scans are then taken. A reference trigger is accepted only once the programmed pretrigger scan count has completed. An earlier one is dropped and sets a sticky error flag. The block exports a one-cycle start pulse, a one-cycle pulse for each scan begun, a conversion strobe with its channel index, and a hold-complete pulse a fixed number of cycles after each conversion. A done pulse marks the final conversion.

Top module: `scan_seq_ctrl`

## Requirements
- R1: Configuration inputs are captured on `cfg_we` only while `busy` is low. A write while busy is dropped, and the following acquisitions use the last values captured while idle.
- R2: From idle, a one-cycle `start_sw` pulse or a rising edge on `start_hw` starts an acquisition. `start_pulse` and `busy` go high in the cycle after the request. A level held high on `start_hw` does not start a second acquisition.
- R3: The first scan begins after the start delay has been counted in timebase ticks. With `tb_tick` high every cycle, `samp_pulse` follows `start_pulse` by `cfg_start_dly`+1 cycles.
- R4: Each scan emits one `conv_strobe` per accepted convert tick. `chan_idx` takes the values 0, 1, … up to `cfg_last_chan` in order.
- R5: A sample tick while a scan still has channels to convert is dropped and is not queued. This includes a sample tick in the same cycle as the final conversion.
- R6: A convert tick while no scan is open is dropped. This includes a convert tick in the same cycle as the sample tick that opens a scan.
- R7: With the internal source selected, a clock ticks once every N timebase ticks, where N is the divider value and 0 acts as 1. With the external source selected, it ticks on a rising edge of the input when the fall select is 0, or on a falling edge when it is 1.
- R8: In normal mode `done` is high for one cycle, together with the final `conv_strobe` of scan number `cfg_scan_num`. In that same cycle `busy` is low.
- R9: In pretrigger mode, scans repeat until a reference trigger (rising edge of `ref_trig`) is accepted. Exactly `cfg_scan_num` further scans are then completed before `done`.
- R10: A reference edge that arrives before `cfg_pre_num` scans have completed is ignored and sets `ref_early_err`. The flag holds until the next start. Reference edges after acceptance are ignored.
- R11: `hold_out` carries a one-cycle pulse HOLD_LAT cycles after each `conv_strobe`. It is active high when `cfg_hold_pol` is 0 and active low when it is 1.
- R12: `start_pulse`, `samp_pulse`, `conv_strobe` and `done` are active-high single-cycle pulses, whatever source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Capture configuration (idle only) |
| cfg_start_dly | input | DLY_W | Timebase ticks from start to first scan |
| cfg_scan_num | input | CNT_W | Scans in normal mode, posttrigger scans in pretrigger mode |
| cfg_pre_num | input | CNT_W | Scans required before a reference trigger is accepted |
| cfg_last_chan | input | CH_W | Index of the last channel of a scan |
| cfg_pretrig_en | input | 1 | 1 selects pretrigger mode |
| cfg_samp_ext | input | 1 | Sample clock from external input (1) or divider (0) |
| cfg_conv_ext | input | 1 | Convert clock from external input (1) or divider (0) |
| cfg_samp_fall | input | 1 | External sample clock on falling edge |
| cfg_conv_fall | input | 1 | External convert clock on falling edge |
| cfg_samp_div | input | DIV_W | Sample divider in timebase ticks |
| cfg_conv_div | input | DIV_W | Convert divider in timebase ticks |
| cfg_hold_pol | input | 1 | 1 makes the hold-complete output active low |
| start_sw | input | 1 | Software start pulse |
| start_hw | input | 1 | Hardware start level (rising edge starts) |
| ref_trig | input | 1 | Reference trigger level (rising edge) |
| tb_tick | input | 1 | Timebase enable pulse |
| samp_ext_in | input | 1 | External sample clock level |
| conv_ext_in | input | 1 | External convert clock level |
| busy | output | 1 | Acquisition in progress |
| start_pulse | output | 1 | Exported start trigger pulse |
| samp_pulse | output | 1 | Exported pulse for each scan begun |
| conv_strobe | output | 1 | Conversion strobe |
| chan_idx | output | CH_W | Channel of the current strobe |
| hold_out | output | 1 | Hold-complete pulse |
| done | output | 1 | Final conversion of the acquisition |
| ref_early_err | output | 1 | Sticky early-reference error |

## Verification
A sample tick and a convert tick can land in the same cycle. What happens depends on whether a scan is open. If the convert tick is the last channel of the scan, the sample tick must be dropped. If no scan is open, the sample tick opens one and the convert tick is dropped. The bench selects external sources for both clocks and raises both inputs in one cycle, in each of those two situations. It then judges by the counts of scan pulses and strobes and by the channel index sequence that follows.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2
    } scan_st_e;
endpackage

// File: rtl/scan_edge_det.sv
`timescale 1ns/1ps
module scan_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic fall,
    output logic edge_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
        edge_o = fall ? (prev_q & ~sig) : (~prev_q & sig);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/scan_tick_src.sv
`timescale 1ns/1ps
module scan_tick_src #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tb_tick,
    input  logic             use_ext,
    input  logic             ext_sig,
    input  logic             ext_fall,
    input  logic [DIV_W-1:0] div,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] div_m1;
    logic             int_tick;
    logic             ext_edge;

    scan_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (ext_sig),
        .fall  (ext_fall),
        .edge_o(ext_edge)
    );

    always_comb begin
        div_m1   = (div == '0) ? '0 : (div - ONE);
        cnt_d    = cnt_q;
        int_tick = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (tb_tick) begin
            if (cnt_q >= div_m1) begin
                int_tick = 1'b1;
                cnt_d    = '0;
            end else begin
                cnt_d = cnt_q + ONE;
            end
        end
        tick_o = run & (use_ext ? ext_edge : int_tick);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/scan_hold_gen.sv
`timescale 1ns/1ps
module scan_hold_gen #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic pol,
    output logic hold_o
);
    logic [LAT-1:0] sr_d, sr_q;

    generate
        if (LAT == 1) begin : g_one
            always_comb sr_d = strobe;
        end else begin : g_many
            always_comb sr_d = {sr_q[LAT-2:0], strobe};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign hold_o = sr_q[LAT-1] ^ pol;
endmodule

// File: rtl/scan_seq_ctrl.sv
`timescale 1ns/1ps
module scan_seq_ctrl #(
    parameter int DLY_W    = 16,
    parameter int CNT_W    = 16,
    parameter int CH_W     = 4,
    parameter int DIV_W    = 16,
    parameter int HOLD_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DLY_W-1:0] cfg_start_dly,
    input  logic [CNT_W-1:0] cfg_scan_num,
    input  logic [CNT_W-1:0] cfg_pre_num,
    input  logic [CH_W-1:0]  cfg_last_chan,
    input  logic             cfg_pretrig_en,
    input  logic             cfg_samp_ext,
    input  logic             cfg_conv_ext,
    input  logic             cfg_samp_fall,
    input  logic             cfg_conv_fall,
    input  logic [DIV_W-1:0] cfg_samp_div,
    input  logic [DIV_W-1:0] cfg_conv_div,
    input  logic             cfg_hold_pol,
    input  logic             start_sw,
    input  logic             start_hw,
    input  logic             ref_trig,
    input  logic             tb_tick,
    input  logic             samp_ext_in,
    input  logic             conv_ext_in,
    output logic             busy,
    output logic             start_pulse,
    output logic             samp_pulse,
    output logic             conv_strobe,
    output logic [CH_W-1:0]  chan_idx,
    output logic             hold_out,
    output logic             done,
    output logic             ref_early_err
);
    import scan_pkg::*;

    localparam logic [DLY_W-1:0] DLY_ONE = {{(DLY_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CH_W-1:0]  CH_ONE  = {{(CH_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic [CNT_W-1:0] scans;
        logic [CNT_W-1:0] pre;
        logic [CH_W-1:0]  last;
        logic             pretrig;
        logic             samp_ext;
        logic             conv_ext;
        logic             samp_fall;
        logic             conv_fall;
        logic [DIV_W-1:0] samp_div;
        logic [DIV_W-1:0] conv_div;
        logic             hold_pol;
    } cfg_t;

    typedef struct packed {
        scan_st_e         st;
        cfg_t             cfg;
        logic [DLY_W-1:0] dly_cnt;
        logic             in_scan;
        logic [CH_W-1:0]  ch;
        logic [CNT_W-1:0] scan_cnt;
        logic             post;
        logic             ref_err;
        logic             start_pls;
        logic             samp_pls;
        logic             conv_pls;
        logic [CH_W-1:0]  chan_q;
        logic             done_pls;
    } seq_t;

    seq_t d, q;
    cfg_t cfg_in;

    logic hw_edge, ref_edge, start_evt;
    logic samp_tick, conv_tick;
    logic begin_scan, finish_scan, final_scan;
    logic [CNT_W:0] scan_nxt;

    // Edge detection of the start and reference inputs
    scan_edge_det u_start_edge (
        .clk(clk), .rst_n(rst_n), .sig(start_hw), .fall(1'b0), .edge_o(hw_edge)
    );
    scan_edge_det u_ref_edge (
        .clk(clk), .rst_n(rst_n), .sig(ref_trig), .fall(1'b0), .edge_o(ref_edge)
    );

    // Sample clock runs for the whole acquisition, convert clock only inside a scan
    scan_tick_src #(.DIV_W(DIV_W)) u_samp_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.st == ST_RUN),
        .tb_tick (tb_tick),
        .use_ext (q.cfg.samp_ext),
        .ext_sig (samp_ext_in),
        .ext_fall(q.cfg.samp_fall),
        .div     (q.cfg.samp_div),
        .tick_o  (samp_tick)
    );
    scan_tick_src #(.DIV_W(DIV_W)) u_conv_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.in_scan),
        .tb_tick (tb_tick),
        .use_ext (q.cfg.conv_ext),
        .ext_sig (conv_ext_in),
        .ext_fall(q.cfg.conv_fall),
        .div     (q.cfg.conv_div),
        .tick_o  (conv_tick)
    );

    scan_hold_gen #(.LAT(HOLD_LAT)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(q.conv_pls),
        .pol   (q.cfg.hold_pol),
        .hold_o(hold_out)
    );

    always_comb begin
        cfg_in.dly       = cfg_start_dly;
        cfg_in.scans     = cfg_scan_num;
        cfg_in.pre       = cfg_pre_num;
        cfg_in.last      = cfg_last_chan;
        cfg_in.pretrig   = cfg_pretrig_en;
        cfg_in.samp_ext  = cfg_samp_ext;
        cfg_in.conv_ext  = cfg_conv_ext;
        cfg_in.samp_fall = cfg_samp_fall;
        cfg_in.conv_fall = cfg_conv_fall;
        cfg_in.samp_div  = cfg_samp_div;
        cfg_in.conv_div  = cfg_conv_div;
        cfg_in.hold_pol  = cfg_hold_pol;
    end

    assign start_evt = start_sw | hw_edge;
    assign scan_nxt  = {1'b0, q.scan_cnt} + {{CNT_W{1'b0}}, 1'b1};

    always_comb begin
        d             = q;
        d.start_pls   = 1'b0;
        d.samp_pls    = 1'b0;
        d.conv_pls    = 1'b0;
        d.done_pls    = 1'b0;
        begin_scan    = 1'b0;
        finish_scan   = 1'b0;
        final_scan    = 1'b0;

        if (cfg_we && (q.st == ST_IDLE)) d.cfg = cfg_in;

        unique case (q.st)
            ST_IDLE: begin
                if (start_evt) begin
                    d.st        = ST_DELAY;
                    d.dly_cnt   = '0;
                    d.scan_cnt  = '0;
                    d.post      = 1'b0;
                    d.ref_err   = 1'b0;
                    d.in_scan   = 1'b0;
                    d.start_pls = 1'b1;
                end
            end
            ST_DELAY: begin
                if (q.dly_cnt >= q.cfg.dly) begin
                    begin_scan = 1'b1;
                end else if (tb_tick) begin
                    d.dly_cnt = q.dly_cnt + DLY_ONE;
                end
            end
            ST_RUN: begin
                if (conv_tick && q.in_scan) begin
                    d.conv_pls = 1'b1;
                    d.chan_q   = q.ch;
                    if (q.ch == q.cfg.last) begin
                        finish_scan = 1'b1;
                        d.in_scan   = 1'b0;
                    end else begin
                        d.ch = q.ch + CH_ONE;
                    end
                end else if (samp_tick && !q.in_scan) begin
                    begin_scan = 1'b1;
                end

                if (finish_scan && (q.scan_cnt != '1)) d.scan_cnt = q.scan_cnt + CNT_ONE;

                // Reference trigger closes the pretrigger phase once enough scans exist
                if (ref_edge && q.cfg.pretrig && !q.post) begin
                    if (q.scan_cnt >= q.cfg.pre) begin
                        d.post     = 1'b1;
                        d.scan_cnt = '0;
                    end else begin
                        d.ref_err = 1'b1;
                    end
                end

                if (finish_scan && (!q.cfg.pretrig || q.post) &&
                    (scan_nxt >= {1'b0, q.cfg.scans})) begin
                    final_scan = 1'b1;
                end
                if (final_scan) begin
                    d.st       = ST_IDLE;
                    d.done_pls = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (begin_scan) begin
            d.st       = ST_RUN;
            d.in_scan  = 1'b1;
            d.ch       = '0;
            d.samp_pls = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy          = (q.st != ST_IDLE);
    assign start_pulse   = q.start_pls;
    assign samp_pulse    = q.samp_pls;
    assign conv_strobe   = q.conv_pls;
    assign chan_idx      = q.chan_q;
    assign done          = q.done_pls;
    assign ref_early_err = q.ref_err;
endmodule

// File: rtl/scan_seq_ctrl_chk.sv
`timescale 1ns/1ps
module scan_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic start_pulse,
    input logic samp_pulse,
    input logic conv_strobe,
    input logic done,
    input logic ref_early_err
);
    assert_done_on_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> conv_strobe);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_no_samp_with_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_pulse && conv_strobe));

    assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> !conv_strobe);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> busy);

    assert_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    assert_err_rise_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_early_err) |-> busy);
endmodule

bind scan_seq_ctrl scan_seq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .start_pulse  (start_pulse),
    .samp_pulse   (samp_pulse),
    .conv_strobe  (conv_strobe),
    .done         (done),
    .ref_early_err(ref_early_err)
);

// File: tb/scan_seq_ctrl_tb.sv
`timescale 1ns/1ps
module scan_seq_ctrl_tb;
    localparam int HL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [15:0] cfg_start_dly = '0;
    logic [15:0] cfg_scan_num = '0;
    logic [15:0] cfg_pre_num = '0;
    logic [3:0]  cfg_last_chan = '0;
    logic cfg_pretrig_en = 1'b0, cfg_samp_ext = 1'b0, cfg_conv_ext = 1'b0;
    logic cfg_samp_fall = 1'b0, cfg_conv_fall = 1'b0, cfg_hold_pol = 1'b0;
    logic [15:0] cfg_samp_div = '0, cfg_conv_div = '0;
    logic start_sw = 1'b0, start_hw = 1'b0, ref_trig = 1'b0, tb_tick = 1'b1;
    logic samp_ext_in = 1'b0, conv_ext_in = 1'b0;
    logic busy, start_pulse, samp_pulse, conv_strobe, hold_out, done, ref_early_err;
    logic [3:0] chan_idx;

    scan_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_start_dly(cfg_start_dly), .cfg_scan_num(cfg_scan_num),
        .cfg_pre_num(cfg_pre_num), .cfg_last_chan(cfg_last_chan),
        .cfg_pretrig_en(cfg_pretrig_en), .cfg_samp_ext(cfg_samp_ext),
        .cfg_conv_ext(cfg_conv_ext), .cfg_samp_fall(cfg_samp_fall),
        .cfg_conv_fall(cfg_conv_fall), .cfg_samp_div(cfg_samp_div),
        .cfg_conv_div(cfg_conv_div), .cfg_hold_pol(cfg_hold_pol),
        .start_sw(start_sw), .start_hw(start_hw), .ref_trig(ref_trig),
        .tb_tick(tb_tick), .samp_ext_in(samp_ext_in), .conv_ext_in(conv_ext_in),
        .busy(busy), .start_pulse(start_pulse), .samp_pulse(samp_pulse),
        .conv_strobe(conv_strobe), .chan_idx(chan_idx), .hold_out(hold_out),
        .done(done), .ref_early_err(ref_early_err)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int n_conv = 0, n_samp = 0, n_start = 0, n_done = 0, n_done_alone = 0;
    int start_cyc = 0, first_samp_cyc = 0, conv1_cyc = 0, conv2_cyc = 0;
    int hold_bad = 0;
    bit hold_en = 1'b0;
    bit tb_pol = 1'b0;
    logic [HL-1:0] hist = '0;
    logic [3:0] ch_log [64];

    // Output monitor, sampled on the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (start_pulse) begin n_start = n_start + 1; start_cyc = cyc; end
        if (samp_pulse) begin
            if (n_samp == 0) first_samp_cyc = cyc;
            n_samp = n_samp + 1;
        end
        if (conv_strobe) begin
            if (n_conv < 64) ch_log[n_conv] = chan_idx;
            if (n_conv == 0) conv1_cyc = cyc;
            if (n_conv == 1) conv2_cyc = cyc;
            n_conv = n_conv + 1;
        end
        if (done) begin
            n_done = n_done + 1;
            if (!conv_strobe) n_done_alone = n_done_alone + 1;
        end
        if (hold_en && ((hold_out ^ tb_pol) !== hist[HL-1])) hold_bad = hold_bad + 1;
        hist = {hist[HL-2:0], conv_strobe};
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        tick(1);
        n_conv = 0; n_samp = 0; n_start = 0; n_done = 0; n_done_alone = 0;
    endtask

    task automatic set_defaults();
        cfg_start_dly = 0; cfg_scan_num = 1; cfg_pre_num = 0; cfg_last_chan = 0;
        cfg_pretrig_en = 0; cfg_samp_ext = 0; cfg_conv_ext = 0;
        cfg_samp_fall = 0; cfg_conv_fall = 0; cfg_hold_pol = 0;
        cfg_samp_div = 20; cfg_conv_div = 2;
    endtask

    task automatic write_cfg();
        cfg_we = 1; tick(1); cfg_we = 0; tick(1);
    endtask

    task automatic start_acq();
        start_sw = 1; tick(1); start_sw = 0;
    endtask

    task automatic pulse_samp();
        samp_ext_in = 1; tick(1); samp_ext_in = 0; tick(1);
    endtask

    task automatic pulse_conv();
        conv_ext_in = ~conv_ext_in; tick(1); conv_ext_in = ~conv_ext_in; tick(1);
    endtask

    task automatic pulse_ref();
        ref_trig = 1; tick(1); ref_trig = 0; tick(1);
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        while (busy && k < 5000) begin tick(1); k++; end
        tick(2);
        chk({req, " acquisition ends"}, int'(busy), 0);
    endtask

    task automatic wait_conv(input int n);
        int k = 0;
        while (n_conv < n && k < 5000) begin tick(1); k++; end
    endtask

    task automatic wait_samp(input int n);
        int k = 0;
        while (n_samp < n && k < 5000) begin tick(1); k++; end
    endtask

    task automatic t_reset();
        chk("R2 reset busy", int'(busy), 0);
        chk("R12 reset strobe", int'(conv_strobe), 0);
        chk("R11 reset hold level", int'(hold_out), 0);
        chk("R10 reset err", int'(ref_early_err), 0);
    endtask

    task automatic t_basic();
        set_defaults();
        cfg_start_dly = 4; cfg_last_chan = 2; cfg_scan_num = 2;
        write_cfg(); clr_counts();
        start_acq();
        wait_idle("R8");
        chk("R2 start pulses", n_start, 1);
        chk("R3 start to first scan gap", first_samp_cyc - start_cyc, 5);
        chk("R7 internal convert spacing", conv2_cyc - conv1_cyc, 2);
        chk("R7 internal sample count", n_samp, 2);
        chk("R4 strobe count", n_conv, 6);
        for (int i = 0; i < 6; i++) chk("R4 channel order", int'(ch_log[i]), i % 3);
        chk("R8 done count", n_done, 1);
        chk("R8 done with final strobe", n_done_alone, 0);
    endtask

    task automatic t_hold();
        set_defaults();
        cfg_hold_pol = 1; cfg_conv_div = 3; cfg_last_chan = 3;
        write_cfg(); tb_pol = 1; tick(2);
        chk("R11 idle level inverted", int'(hold_out), 1);
        hist = '0; hold_bad = 0; hold_en = 1; clr_counts();
        start_acq();
        wait_idle("R11");
        tick(HL + 2);
        hold_en = 0;
        chk("R11 hold pulse timing", hold_bad, 0);
        chk("R11 strobes seen", n_conv, 4);
        set_defaults(); write_cfg(); tb_pol = 0;
    endtask

    task automatic t_hw_start();
        set_defaults(); write_cfg(); clr_counts();
        start_hw = 1;
        tick(3);
        wait_idle("R2");
        tick(10);
        chk("R2 held level no restart", n_start, 1);
        chk("R2 hw start busy", int'(busy), 0);
        start_hw = 0; tick(2);
    endtask

    task automatic t_samp_drop();
        set_defaults();
        cfg_samp_ext = 1; cfg_conv_div = 4; cfg_last_chan = 2; cfg_scan_num = 2;
        write_cfg(); clr_counts();
        start_acq();
        wait_samp(1);
        tick(2); pulse_samp();
        tick(2); pulse_samp();
        wait_conv(3);
        tick(20);
        chk("R5 mid-scan sample dropped", n_samp, 1);
        chk("R5 no queued scan strobes", n_conv, 3);
        pulse_samp();
        wait_idle("R5");
        chk("R5 later sample opens scan", n_samp, 2);
        chk("R5 total strobes", n_conv, 6);
    endtask

    task automatic t_conv_ignore();
        set_defaults();
        conv_ext_in = 1;
        cfg_conv_ext = 1; cfg_conv_fall = 1; cfg_samp_div = 60;
        cfg_last_chan = 1; cfg_scan_num = 2;
        write_cfg(); clr_counts();
        start_acq();
        wait_samp(1);
        for (int i = 0; i < 4; i++) begin pulse_conv(); tick(1); end
        chk("R6 extra converts dropped", n_conv, 2);
        wait_samp(2);
        tick(2);
        pulse_conv(); tick(2);
        chk("R7 falling edge only", n_conv, 3);
        pulse_conv();
        wait_idle("R7");
        chk("R7 second scan strobes", n_conv, 4);
        conv_ext_in = 0; tick(2);
    endtask

    task automatic t_collide();
        set_defaults();
        cfg_samp_ext = 1; cfg_conv_ext = 1; cfg_last_chan = 1; cfg_scan_num = 3;
        write_cfg(); clr_counts();
        start_acq();
        wait_samp(1); tick(2);
        pulse_conv();
        samp_ext_in = 1; conv_ext_in = 1; tick(1);
        samp_ext_in = 0; conv_ext_in = 0; tick(4);
        chk("R5 sample with last convert dropped", n_samp, 1);
        chk("R5 last convert taken", n_conv, 2);
        chk("R4 last channel index", int'(ch_log[1]), 1);
        pulse_samp(); tick(2);
        pulse_conv(); pulse_conv(); tick(2);
        chk("R4 second scan strobes", n_conv, 4);
        samp_ext_in = 1; conv_ext_in = 1; tick(1);
        samp_ext_in = 0; conv_ext_in = 0; tick(4);
        chk("R6 convert at scan open dropped", n_conv, 4);
        chk("R6 scan opened", n_samp, 3);
        pulse_conv(); pulse_conv();
        wait_idle("R6");
        chk("R8 collide total strobes", n_conv, 6);
        chk("R4 third scan first index", int'(ch_log[4]), 0);
    endtask

    task automatic t_pretrig();
        set_defaults();
        cfg_pretrig_en = 1; cfg_pre_num = 3; cfg_scan_num = 2;
        cfg_samp_div = 12; cfg_conv_div = 1; cfg_last_chan = 1;
        write_cfg(); clr_counts();
        start_acq();
        wait_conv(2); tick(1);
        pulse_ref(); tick(2);
        chk("R10 early ref flagged", int'(ref_early_err), 1);
        chk("R10 early ref keeps running", int'(busy), 1);
        wait_conv(8); tick(1);
        pulse_ref();
        wait_conv(10); tick(1);
        pulse_ref();
        wait_idle("R9");
        chk("R9 pre plus post strobes", n_conv, 12);
        chk("R9 done count", n_done, 1);
        chk("R10 flag sticky", int'(ref_early_err), 1);
        clr_counts();
        start_acq(); tick(1);
        chk("R10 flag cleared by start", int'(ref_early_err), 0);
        wait_conv(6); tick(1);
        pulse_ref();
        wait_idle("R9");
        chk("R9 exact pre count accepted", n_conv, 10);
        chk("R10 no flag on timely ref", int'(ref_early_err), 0);
    endtask

    task automatic t_cfg_busy();
        set_defaults();
        cfg_conv_div = 3; cfg_last_chan = 1;
        write_cfg(); clr_counts();
        start_acq(); tick(1);
        cfg_last_chan = 3; cfg_we = 1; tick(1); cfg_we = 0;
        wait_idle("R1");
        chk("R1 busy write dropped", n_conv, 2);
        clr_counts();
        start_acq();
        wait_idle("R1");
        chk("R1 idle config kept", n_conv, 2);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        set_defaults();
        tick(3);
        rst_n = 1;
        tick(2);
        t_reset();
        t_basic();
        t_hold();
        t_hw_start();
        t_samp_drop();
        t_conv_ignore();
        t_collide();
        t_pretrig();
        t_cfg_busy();
        finish_run();
    end
endmodule